// File: doc/BRIEF.md
# Processor Reset Exception Sequencer

This block governs how a processor core comes out of reset. While the reset input is low, it holds the status register, the vector base register and the boot pointers at fixed reset values. It also keeps the local-memory configuration invalidated, and any work in progress is dropped.

Once reset is released, the release is synchronised to the clock. The block then counts a fixed wait window, and during that window it samples a debug halt request. If no halt was requested, it issues two longword reads on a simple request/acknowledge read port. The longword at address 0 becomes the initial stack pointer and the longword at address 4 becomes the initial program counter. It then raises a run enable so that the core fetches from that program counter.

A failure before the first instruction retires parks the block in a double-fault halt that only a new reset can clear. Three failures count: an error response on either boot read, a loaded program counter that is not word aligned, or a fault reported on the first instruction.

Top module: `boot_sequencer`

## Requirements
- R1: While `rst_n` is low, and asynchronously to the clock, the outputs take their reset values. `sr_o` = 0x2700: bit 15 (trace) is 0, bit 13 (supervisor) is 1, bit 12 (master) is 0, and bits 10:8 (interrupt mask) are 111. `vbr_o`, `sp_o` and `pc_o` are 0. `run_o`, `halted_o`, `dbl_fault_o` and `rd_req` are 0, and `lmem_inval_o` is 1.
- R2: Release of `rst_n` passes through a 2-stage synchroniser and is followed by a 16-cycle wait. `rd_req` is 0 after the 17th rising edge that follows release and becomes 1 after the 18th (unless a debug halt was taken).
- R3: A high `dbg_halt_req` at any rising edge of the wait window (edges 3 to 18 after release) sends the block to a halt without reads: `halted_o` = 1 and `dbl_fault_o` = 0. A request during reset, during synchronisation or after the window has no effect.
- R4: The first read presents `rd_addr` = 0, and its data is loaded into `sp_o`.
- R5: The second read presents `rd_addr` = 4, and its data is loaded into `pc_o`. Each request holds `rd_req` and `rd_addr` steady until the cycle in which `rd_ack` is high.
- R6: If `rd_err` is high with `rd_ack` on either boot read, the block enters the double-fault halt (`halted_o` = 1, `dbl_fault_o` = 1). No read is issued after the failing one.
- R7: A second-read longword with bit 0 set is an address error and gives the double-fault halt. `run_o` never rises in that case.
- R8: After a clean second read, `run_o` is 1. If `insn_fault` is high before `insn_retire` has been seen, the block enters the double-fault halt; if both are high in the same cycle, the fault wins. Once the first instruction has retired, `insn_fault` has no effect.
- R9: A halt of either kind persists, with no further reads, until `rst_n` is asserted again. Asserting `rst_n` in any state abandons that state and restarts the whole sequence, including the full wait.
- R10: `lmem_inval_o` is 1 during reset and throughout the wait window, and 0 from the first read onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset input |
| dbg_halt_req | input | 1 | Debug breakpoint halt request |
| rd_req | output | 1 | Boot read request |
| rd_addr | output | 32 | Boot read address |
| rd_ack | input | 1 | Read acknowledge, data and error valid |
| rd_err | input | 1 | Read error response |
| rd_data | input | 32 | Read data longword |
| insn_retire | input | 1 | Core reports an instruction retired |
| insn_fault | input | 1 | Core reports an access or address error |
| sr_o | output | 16 | Status register |
| vbr_o | output | 32 | Vector base register |
| sp_o | output | 32 | Stack pointer loaded at boot |
| pc_o | output | 32 | Program counter loaded at boot |
| lmem_inval_o | output | 1 | Local-memory configuration invalidated |
| run_o | output | 1 | Instruction fetch enable |
| halted_o | output | 1 | Core halted |
| dbl_fault_o | output | 1 | Halt is a double fault |

## Verification
The debug request is swept as a one-cycle pulse over every cycle from release to well past the window. This separates the sample boundaries (edges 3 and 18) from their neighbours on either side. Clean boots with distinct stack and program values and read latencies of 0 to 3 cycles show that each read goes to its own address and its data reaches the right register, with no dependence on acknowledge timing. Error responses on each read, an odd program counter, a first-instruction fault, and a fault after retire tell apart the three double-fault causes and the one fault that must be ignored. Resets applied mid-wait, mid-run and from a halt confirm that the sequence restarts.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

  typedef enum logic [2:0] {
    BS_WAIT,
    BS_FETCH_SP,
    BS_FETCH_PC,
    BS_FIRST,
    BS_RUN,
    BS_DBG_HALT,
    BS_DBL_FAULT
  } bs_state_e;

  // trace=0 (15), supervisor=1 (13), master=0 (12), mask=111 (10:8)
  localparam logic [15:0] SR_RESET = 16'h2700;

endpackage

// File: rtl/boot_rst_sync.sv
module boot_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_s
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES > 1) begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end else begin : g_single
      always_comb sync_d = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_n_s = sync_q[STAGES-1];

endmodule

// File: rtl/boot_wait_timer.sv
module boot_wait_timer #(
  parameter int WAIT_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic count_en,
  output logic expire_o
);

  localparam int CNT_W = $clog2(WAIT_CYCLES) + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ce;

  assign expire_o = count_en && (cnt_q == LAST);
  assign cnt_ce   = count_en && !expire_o;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_ce) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: the window counter never runs past its last value
  a_r2_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/boot_arch_regs.sv
module boot_arch_regs
  import boot_seq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_sp,
  input  logic              ld_pc,
  input  logic [DATA_W-1:0] ld_data,
  output logic [15:0]       sr_o,
  output logic [DATA_W-1:0] vbr_o,
  output logic [DATA_W-1:0] sp_o,
  output logic [DATA_W-1:0] pc_o
);

  logic [15:0]       sr_q,  sr_d;
  logic [DATA_W-1:0] vbr_q, vbr_d;
  logic [DATA_W-1:0] sp_q,  sp_d;
  logic [DATA_W-1:0] pc_q,  pc_d;

  always_comb begin
    sr_d  = sr_q;
    vbr_d = vbr_q;
    sp_d  = ld_sp ? ld_data : sp_q;
    pc_d  = ld_pc ? ld_data : pc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= SR_RESET;
      vbr_q <= '0;
      sp_q  <= '0;
      pc_q  <= '0;
    end else begin
      sr_q  <= sr_d;
      vbr_q <= vbr_d;
      sp_q  <= sp_d;
      pc_q  <= pc_d;
    end
  end

  assign sr_o  = sr_q;
  assign vbr_o = vbr_q;
  assign sp_o  = sp_q;
  assign pc_o  = pc_q;

  // R4/R5: the two boot loads are never requested together
  a_r4_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_sp && ld_pc));

endmodule

// File: rtl/boot_sequencer.sv
module boot_sequencer
  import boot_seq_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int WAIT_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_halt_req,
  output logic              rd_req,
  output logic [DATA_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic              rd_err,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              insn_retire,
  input  logic              insn_fault,
  output logic [15:0]       sr_o,
  output logic [DATA_W-1:0] vbr_o,
  output logic [DATA_W-1:0] sp_o,
  output logic [DATA_W-1:0] pc_o,
  output logic              lmem_inval_o,
  output logic              run_o,
  output logic              halted_o,
  output logic              dbl_fault_o
);

  localparam logic [DATA_W-1:0] SP_ADDR = '0;
  localparam logic [DATA_W-1:0] PC_ADDR = DATA_W'(DATA_W / 8);

  logic      rst_n_s;
  bs_state_e state_q, state_d;
  logic      dbg_seen_q, dbg_seen_d;
  logic      tmr_expire;
  logic      in_wait;
  logic      ld_sp, ld_pc;
  logic      rd_good;

  boot_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n_a (rst_n),
    .rst_n_s (rst_n_s)
  );

  assign in_wait = (state_q == BS_WAIT);

  boot_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .count_en (in_wait),
    .expire_o (tmr_expire)
  );

  assign rd_good = rd_ack && !rd_err;
  assign ld_sp   = (state_q == BS_FETCH_SP) && rd_good;
  assign ld_pc   = (state_q == BS_FETCH_PC) && rd_good && !rd_data[0];

  boot_arch_regs #(.DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .ld_sp   (ld_sp),
    .ld_pc   (ld_pc),
    .ld_data (rd_data),
    .sr_o    (sr_o),
    .vbr_o   (vbr_o),
    .sp_o    (sp_o),
    .pc_o    (pc_o)
  );

  // next-state logic
  always_comb begin
    state_d    = state_q;
    dbg_seen_d = dbg_seen_q | (in_wait && dbg_halt_req);
    case (state_q)
      BS_WAIT:
        if (tmr_expire)
          state_d = (dbg_seen_q || dbg_halt_req) ? BS_DBG_HALT : BS_FETCH_SP;
      BS_FETCH_SP:
        if (rd_ack) state_d = rd_err ? BS_DBL_FAULT : BS_FETCH_PC;
      BS_FETCH_PC:
        if (rd_ack) state_d = (rd_err || rd_data[0]) ? BS_DBL_FAULT : BS_FIRST;
      BS_FIRST:
        if (insn_fault)       state_d = BS_DBL_FAULT;
        else if (insn_retire) state_d = BS_RUN;
      default: state_d = state_q;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q    <= BS_WAIT;
      dbg_seen_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      dbg_seen_q <= dbg_seen_d;
    end
  end

  assign rd_req       = (state_q == BS_FETCH_SP) || (state_q == BS_FETCH_PC);
  assign rd_addr      = (state_q == BS_FETCH_PC) ? PC_ADDR : SP_ADDR;
  assign lmem_inval_o = in_wait;
  assign run_o        = (state_q == BS_FIRST) || (state_q == BS_RUN);
  assign halted_o     = (state_q == BS_DBG_HALT) || (state_q == BS_DBL_FAULT);
  assign dbl_fault_o  = (state_q == BS_DBL_FAULT);

  // R5: an unanswered request holds its address
  a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

  // R3: a debug halt never issues a read
  a_r3_dbg_no_read: assert property (@(posedge clk) disable iff (!rst_n_s)
    (halted_o && !dbl_fault_o) |-> !rd_req);

  // R6: an error on the first boot read ends in double fault
  a_r6_sp_err: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_req && rd_addr == SP_ADDR && rd_ack && rd_err) |=> dbl_fault_o);

  // R7: fetch is never enabled with an odd program counter
  a_r7_pc_even: assert property (@(posedge clk) disable iff (!rst_n_s)
    run_o |-> !pc_o[0]);

  // R8: running and halted exclude each other
  a_r8_run_xor_halt: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(run_o && halted_o));

  // R9: a halt is left only through reset
  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n_s)
    halted_o |=> (halted_o && $stable(dbl_fault_o)));

endmodule

// File: tb/sim_boot_sequencer.sv
module sim_boot_sequencer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        dbg_halt_req;
  logic        rd_req;
  logic [31:0] rd_addr;
  logic        rd_ack;
  logic        rd_err;
  logic [31:0] rd_data;
  logic        insn_retire;
  logic        insn_fault;
  logic [15:0] sr_o;
  logic [31:0] vbr_o, sp_o, pc_o;
  logic        lmem_inval_o, run_o, halted_o, dbl_fault_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // memory model controls
  logic [31:0] m_sp, m_pc;
  int          mem_lat;
  bit          err_sp, err_pc;
  int          lat_cnt;
  int          n_acks;
  logic [31:0] addr0, addr1;

  always #4 clk = ~clk;

  boot_sequencer u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .dbg_halt_req (dbg_halt_req),
    .rd_req       (rd_req),
    .rd_addr      (rd_addr),
    .rd_ack       (rd_ack),
    .rd_err       (rd_err),
    .rd_data      (rd_data),
    .insn_retire  (insn_retire),
    .insn_fault   (insn_fault),
    .sr_o         (sr_o),
    .vbr_o        (vbr_o),
    .sp_o         (sp_o),
    .pc_o         (pc_o),
    .lmem_inval_o (lmem_inval_o),
    .run_o        (run_o),
    .halted_o     (halted_o),
    .dbl_fault_o  (dbl_fault_o)
  );

  always @(negedge clk) begin
    if (!rst_n) begin
      rd_ack <= 1'b0; rd_err <= 1'b0; rd_data <= '0;
      lat_cnt <= 0; n_acks <= 0; addr0 <= '1; addr1 <= '1;
    end else if (rd_ack) begin
      rd_ack <= 1'b0; rd_err <= 1'b0; lat_cnt <= 0;
    end else if (rd_req) begin
      if (lat_cnt == mem_lat) begin
        rd_ack  <= 1'b1;
        rd_data <= (rd_addr == 32'd0) ? m_sp :
                   (rd_addr == 32'd4) ? m_pc : 32'hDEAD_BEEF;
        rd_err  <= ((rd_addr == 32'd0) && err_sp) || ((rd_addr == 32'd4) && err_pc);
        if (n_acks == 0) addr0 <= rd_addr;
        if (n_acks == 1) addr1 <= rd_addr;
        n_acks  <= n_acks + 1;
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic chk_reset_vals(input string tag);
    chk(sr_o == 16'h2700, {tag, " R1 sr"}, {16'h0, sr_o}, 32'h2700);
    chk(vbr_o == 0 && sp_o == 0 && pc_o == 0, {tag, " R1 regs"}, vbr_o | sp_o | pc_o, 0);
    chk({run_o, halted_o, dbl_fault_o, rd_req} == 4'b0, {tag, " R1 flags"},
        {28'h0, run_o, halted_o, dbl_fault_o, rd_req}, 0);
    chk(lmem_inval_o == 1'b1, {tag, " R10 inval in reset"}, {31'h0, lmem_inval_o}, 1);
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_boot(input logic [31:0] sp, input logic [31:0] pc, input int lat,
                          input bit esp, input bit epc, input int dbgk,
                          input bit first_fault);
    bit hdbg;
    m_sp = sp; m_pc = pc; mem_lat = lat; err_sp = esp; err_pc = epc;
    insn_retire = 1'b0; insn_fault = 1'b0;
    rst_n = 1'b0; dbg_halt_req = 1'b1;
    repeat (3) @(negedge clk);
    chk_reset_vals("boot");
    rst_n = 1'b1;
    dbg_halt_req = (dbgk == 0);
    hdbg = (dbgk >= 2) && (dbgk <= 17);
    for (int c = 1; c <= 80; c++) begin
      @(negedge clk);
      if (c == 17) begin
        chk(rd_req == 1'b0, "R2 no read at edge 17", {31'h0, rd_req}, 0);
        chk(lmem_inval_o == 1'b1, "R10 inval in window", {31'h0, lmem_inval_o}, 1);
      end
      if (c == 18) begin
        chk(rd_req == !hdbg, "R2/R3 read start at edge 18", {31'h0, rd_req}, {31'h0, !hdbg});
        chk(lmem_inval_o == 1'b0, "R10 inval after window", {31'h0, lmem_inval_o}, 0);
      end
      dbg_halt_req = (c == dbgk);
    end
    if (hdbg) begin
      chk(halted_o && !dbl_fault_o && !run_o, "R3 debug halt",
          {29'h0, halted_o, dbl_fault_o, run_o}, 32'h4);
      chk(n_acks == 0, "R3/R9 no reads after debug halt", n_acks, 0);
    end else if (esp) begin
      chk(halted_o && dbl_fault_o && !run_o, "R6 sp read error",
          {29'h0, halted_o, dbl_fault_o, run_o}, 32'h6);
      chk(n_acks == 1, "R6 no read after error", n_acks, 1);
    end else if (epc || pc[0]) begin
      chk(halted_o && dbl_fault_o && !run_o, epc ? "R6 pc read error" : "R7 odd pc",
          {29'h0, halted_o, dbl_fault_o, run_o}, 32'h6);
      chk(n_acks == 2, "R6/R7 read count", n_acks, 2);
    end else begin
      chk(run_o && !halted_o, "R8 run after boot", {30'h0, run_o, halted_o}, 32'h2);
      chk(addr0 == 32'd0, "R4 first address", addr0, 0);
      chk(addr1 == 32'd4, "R5 second address", addr1, 4);
      chk(sp_o == sp, "R4 sp loaded", sp_o, sp);
      chk(pc_o == pc, "R5 pc loaded", pc_o, pc);
      if (first_fault) begin
        pulse(insn_fault);
        chk(dbl_fault_o && halted_o && !run_o, "R8 first instruction fault",
            {29'h0, halted_o, dbl_fault_o, run_o}, 32'h6);
        repeat (5) @(negedge clk);
        chk(dbl_fault_o && halted_o, "R9 fault halt persists",
            {30'h0, halted_o, dbl_fault_o}, 32'h3);
      end else begin
        pulse(insn_retire);
        pulse(insn_fault);
        chk(run_o && !halted_o, "R8 late fault ignored", {30'h0, run_o, halted_o}, 32'h2);
      end
    end
  endtask

  initial begin
    rst_n = 1'b0; dbg_halt_req = 1'b0; insn_retire = 1'b0; insn_fault = 1'b0;
    m_sp = '0; m_pc = '0; mem_lat = 0; err_sp = 1'b0; err_pc = 1'b0;
    repeat (2) @(negedge clk);
    chk_reset_vals("initial");

    // debug pulse swept across every cycle around the window
    for (int k = 0; k <= 21; k++)
      run_boot(32'h1000_0000 + 32'(k * 16), 32'h0000_0400 + 32'(k * 4),
               k % 4, 1'b0, 1'b0, k, 1'b0);

    // clean boots, faults, all latencies
    for (int l = 0; l < 4; l++) begin
      run_boot(32'h2000_0F00 ^ 32'(l), 32'h0001_0000 + 32'(l * 2), l, 1'b0, 1'b0, -1, 1'b0);
      run_boot(32'hA5A5_0000, 32'h0000_8000, l, 1'b1, 1'b0, -1, 1'b0);
      run_boot(32'hA5A5_0000, 32'h0000_8000, l, 1'b0, 1'b1, -1, 1'b0);
      run_boot(32'h3000_0000, 32'h0000_8001 + 32'(l * 4), l, 1'b0, 1'b0, -1, 1'b0);
      run_boot(32'h4000_0000, 32'h0000_9000, l, 1'b0, 1'b0, -1, 1'b1);
    end

    // reset while running abandons the run
    run_boot(32'h5555_0000, 32'h0000_0200, 1, 1'b0, 1'b0, -1, 1'b0);
    rst_n = 1'b0;
    #1;
    chk(!run_o, "R9 reset abandons run", {31'h0, run_o}, 0);
    chk_reset_vals("abort");

    // reset during the wait restarts the full window
    mem_lat = 3; err_sp = 1'b0; err_pc = 1'b0; dbg_halt_req = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int c = 1; c <= 18; c++) begin
      @(negedge clk);
      if (c == 17) chk(rd_req == 1'b0, "R9 window restarted edge 17", {31'h0, rd_req}, 0);
      if (c == 18) chk(rd_req == 1'b1, "R9 window restarted edge 18", {31'h0, rd_req}, 1);
    end

    // reset releases a double-fault halt
    run_boot(32'h0, 32'h0000_0011, 0, 1'b0, 1'b0, -1, 1'b0);
    rst_n = 1'b0;
    #1;
    chk(!halted_o && !dbl_fault_o, "R9 reset clears halt", {30'h0, halted_o, dbl_fault_o}, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule